// File: doc/BRIEF.md
# Control Frame Error Injector

This block sits inline in the transmit path of link-layer control frames. Frames arrive as a stream of 16-bit words marked with start and end flags. They leave on a matching output stream one clock later. A command write arms the block with one corruption and an optional 8-bit argument. The next frame of the matching kind is then altered in one protocol field, has a symbol-level error requested, or is removed from the stream. After that the command clears itself. Test logic uses this to provoke a receiver and check how it responds.

Two frame kinds are recognised from the header word. Flow-control frames take CRC, credit-request, reserved-bit, sequence-number, traffic-class, credit and control-code corruptions, plus requests for a symbol error, a disparity error or one extra symbol. PA control frames take CRC inversion, reserved-bit inversion and function-identifier increment. They also take a skip mode that drops the capability frame.

The block does no symbol encoding itself. Symbol, disparity and extra-symbol errors leave as flags, each beside the output word it concerns, for a downstream encoder to act on.

Top module: `ctrl_frame_injector`

## Requirements
- R1: With no command armed, every input word appears on the output one clock later, unchanged, with the same start and end flags. No error flag is raised and no word is added or lost.
- R2: A command applies to the next frame whose kind matches it, and to that frame only. A frame of the other kind leaves the command armed. A write with op 0 disarms the block. A later write replaces an earlier one that has not yet been used.
- R3: injDone pulses for one clock with the output of the last word of a corrupted frame. When the frame is dropped, it pulses in the clock where that last word would have appeared. It never pulses for a frame that is passed unchanged.
- R4: A frame is recognised from the header word (the start word). Bits [15:12] equal to 1 mark a flow-control frame; equal to 2 they mark a PA control frame. The last word of a frame is its CRC. Op 1 inverts the whole last word of a flow-control frame. Op 2 sets header bit 11 (credit request). Op 3 inverts header bits [10:9] (reserved).
- R5: Op 4 adds 1 to the flow-control sequence number in header bits [4:0], and op 5 subtracts 1 from it, both modulo 32.
- R6: Op 6 sets header bit 8 (traffic class) of the next flow-control frame whose bit 8 is 0. Flow-control frames with bit 8 already set pass unchanged and leave the command armed.
- R7: Op 7 replaces bits [7:0] of the second word of a flow-control frame (the credit field) with the argument. Op 8 replaces header bits [7:5] (control code) with argument bits [2:0].
- R8: Ops 9 and 10 raise outSymErr and outDispErr, respectively, beside the header word of the chosen flow-control frame, and beside no other word. Op 11 raises outExtraSym beside that frame's last word. The data is unchanged in all three cases.
- R9: On a PA control frame, op 12 inverts the whole last word, op 13 inverts header bits [7:6] (reserved), and op 14 adds 1 to the function identifier in header bits [11:8], modulo 16.
- R10: Op 15 removes from the output every word of the next PA control frame whose function identifier equals 3 (capability). Other PA frames pass unchanged while the command waits.
- R11: A command written in the same clock as the start word of a matching frame does not affect that frame. It applies to the next matching frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWrite | input | 1 | Loads cmdOp and cmdArg and arms the block |
| cmdOp | input | 4 | Corruption selector (0 disarms; 1 to 15 as in the requirements) |
| cmdArg | input | 8 | Replacement value for the credit and control-code corruptions |
| inValid | input | 1 | Input word is valid |
| inSop | input | 1 | Input word is the header word of a frame |
| inEop | input | 1 | Input word is the last (CRC) word of a frame |
| inData | input | 16 | Input word |
| outValid | output | 1 | Output word is valid |
| outSop | output | 1 | Output word is a header word |
| outEop | output | 1 | Output word is a last word |
| outData | output | 16 | Output word, possibly corrupted |
| outSymErr | output | 1 | Encoder should place a symbol error in this word |
| outDispErr | output | 1 | Encoder should place a disparity error in this word |
| outExtraSym | output | 1 | Encoder should insert one extra symbol after this word |
| injDone | output | 1 | Pulse: the armed corruption has been applied |

## Verification
The command write and the arrival of a matching header word can fall in the same clock. In that case the arming register and the per-frame capture both change at one edge. The bench provokes this by raising cmdWrite in the same cycle as the start word of a flow-control frame. It requires that frame to leave untouched with no injDone, and the following frame to carry the corruption with one injDone. A second case puts a non-matching frame between the write and a matching frame: the command must survive the first frame and hit the second.

// File: rtl/inj_pkg.sv
package inj_pkg;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_FC_CRC   = 4'd1,
    OP_FC_CREQ  = 4'd2,
    OP_FC_RSVD  = 4'd3,
    OP_SEQ_INC  = 4'd4,
    OP_SEQ_DEC  = 4'd5,
    OP_TC_SWAP  = 4'd6,
    OP_CREDIT   = 4'd7,
    OP_CODE     = 4'd8,
    OP_SYM      = 4'd9,
    OP_DISP     = 4'd10,
    OP_EXTRA    = 4'd11,
    OP_PA_CRC   = 4'd12,
    OP_PA_RSVD  = 4'd13,
    OP_FUNC_INC = 4'd14,
    OP_SKIP     = 4'd15
  } injOp_e;

  // Strobes from control to datapath, valid for every word of the current frame
  typedef struct packed {
    logic       invCrc;
    logic       setCreq;
    logic       invFcRsvd;
    logic       seqInc;
    logic       seqDec;
    logic       setTc;
    logic       putCredit;
    logic       putCode;
    logic       symErr;
    logic       dispErr;
    logic       extraSym;
    logic       invPaRsvd;
    logic       funcInc;
    logic       drop;
    logic [7:0] arg;
  } injStrobe_t;

  function automatic logic isPaOp(injOp_e op);
    return (op == OP_PA_CRC) || (op == OP_PA_RSVD) ||
           (op == OP_FUNC_INC) || (op == OP_SKIP);
  endfunction

endpackage

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import inj_pkg::*;
#(
  parameter int KIND_W  = 4,
  parameter int FC_KIND = 1,
  parameter int PA_KIND = 2,
  parameter int FUNC_W  = 4,
  parameter int CAP_FUNC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [3:0]        cmdOp,
  input  logic [7:0]        cmdArg,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [KIND_W-1:0] hdrKind,
  input  logic              hdrTc,
  input  logic [FUNC_W-1:0] hdrFunc,
  output injStrobe_t        strobe,
  output logic              frameOn,
  output logic              injDone
);

  logic       armed;
  injOp_e     armedOp;
  logic [7:0] armedArg;
  logic       activeOn;
  injOp_e     activeOp;
  logic [7:0] activeArg;

  logic       isFc, isPa, match, hit, sopNow;
  injOp_e     curOp;
  logic [7:0] curArg;

  always_comb begin
    isFc   = (hdrKind == KIND_W'(FC_KIND));
    isPa   = (hdrKind == KIND_W'(PA_KIND));
    sopNow = inValid && inSop;
    case (armedOp)
      OP_NONE:    match = 1'b0;
      OP_TC_SWAP: match = isFc && !hdrTc;
      OP_SKIP:    match = isPa && (hdrFunc == FUNC_W'(CAP_FUNC));
      default:    match = isPaOp(armedOp) ? isPa : isFc;
    endcase
    hit     = armed && sopNow && match;
    frameOn = sopNow ? hit : activeOn;
    curOp   = sopNow ? armedOp : activeOp;
    curArg  = sopNow ? armedArg : activeArg;
  end

  always_comb begin
    strobe     = '0;
    strobe.arg = curArg;
    if (frameOn) begin
      case (curOp)
        OP_FC_CRC, OP_PA_CRC: strobe.invCrc    = 1'b1;
        OP_FC_CREQ:           strobe.setCreq   = 1'b1;
        OP_FC_RSVD:           strobe.invFcRsvd = 1'b1;
        OP_SEQ_INC:           strobe.seqInc    = 1'b1;
        OP_SEQ_DEC:           strobe.seqDec    = 1'b1;
        OP_TC_SWAP:           strobe.setTc     = 1'b1;
        OP_CREDIT:            strobe.putCredit = 1'b1;
        OP_CODE:              strobe.putCode   = 1'b1;
        OP_SYM:               strobe.symErr    = 1'b1;
        OP_DISP:              strobe.dispErr   = 1'b1;
        OP_EXTRA:             strobe.extraSym  = 1'b1;
        OP_PA_RSVD:           strobe.invPaRsvd = 1'b1;
        OP_FUNC_INC:          strobe.funcInc   = 1'b1;
        OP_SKIP:              strobe.drop      = 1'b1;
        default:              strobe.drop      = 1'b0;
      endcase
    end
  end

  // Arming: a write wins over the clear caused by a hit in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      armedOp  <= OP_NONE;
      armedArg <= '0;
    end else if (cmdWrite) begin
      armed    <= (cmdOp != 4'd0);
      armedOp  <= injOp_e'(cmdOp);
      armedArg <= cmdArg;
    end else if (hit) begin
      armed    <= 1'b0;
    end
  end

  // Per-frame capture of the command taken at the header word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeOn  <= 1'b0;
      activeOp  <= OP_NONE;
      activeArg <= '0;
      injDone   <= 1'b0;
    end else begin
      injDone <= frameOn && inValid && inEop;
      if (sopNow && !inEop) begin
        activeOn  <= hit;
        activeOp  <= armedOp;
        activeArg <= armedArg;
      end else if (inValid && inEop) begin
        activeOn  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/inj_datapath.sv
module inj_datapath
  import inj_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CREQ_BIT   = 11,
  parameter int FCRSV_LSB  = 9,
  parameter int FCRSV_W    = 2,
  parameter int TC_BIT     = 8,
  parameter int CODE_LSB   = 5,
  parameter int SEQ_LSB    = 0,
  parameter int SEQ_W      = 5,
  parameter int CREDIT_LSB = 0,
  parameter int CREDIT_W   = 8,
  parameter int FUNC_LSB   = 8,
  parameter int FUNC_W     = 4,
  parameter int PARSV_LSB  = 6,
  parameter int PARSV_W    = 2,
  parameter int CRC_LSB    = 0,
  parameter int CRC_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [DATA_W-1:0] inData,
  input  injStrobe_t        strobe,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic [DATA_W-1:0] outData,
  output logic              outSymErr,
  output logic              outDispErr,
  output logic              outExtraSym
);

  localparam int CODE_W = 3;

  logic              afterSop;
  logic [DATA_W-1:0] word;
  logic              keep;

  always_comb begin
    word = inData;
    keep = inValid && !strobe.drop;
    if (inSop) begin
      if (strobe.setCreq)   word[CREQ_BIT] = 1'b1;
      if (strobe.setTc)     word[TC_BIT] = 1'b1;
      if (strobe.invFcRsvd) word[FCRSV_LSB +: FCRSV_W] = ~inData[FCRSV_LSB +: FCRSV_W];
      if (strobe.invPaRsvd) word[PARSV_LSB +: PARSV_W] = ~inData[PARSV_LSB +: PARSV_W];
      if (strobe.seqInc)    word[SEQ_LSB +: SEQ_W] = inData[SEQ_LSB +: SEQ_W] + SEQ_W'(1);
      if (strobe.seqDec)    word[SEQ_LSB +: SEQ_W] = inData[SEQ_LSB +: SEQ_W] - SEQ_W'(1);
      if (strobe.funcInc)   word[FUNC_LSB +: FUNC_W] = inData[FUNC_LSB +: FUNC_W] + FUNC_W'(1);
      if (strobe.putCode)   word[CODE_LSB +: CODE_W] = strobe.arg[CODE_W-1:0];
    end
    if (afterSop && strobe.putCredit)
      word[CREDIT_LSB +: CREDIT_W] = strobe.arg[CREDIT_W-1:0];
    if (inEop && strobe.invCrc)
      word[CRC_LSB +: CRC_W] = ~inData[CRC_LSB +: CRC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      afterSop    <= 1'b0;
      outValid    <= 1'b0;
      outSop      <= 1'b0;
      outEop      <= 1'b0;
      outData     <= '0;
      outSymErr   <= 1'b0;
      outDispErr  <= 1'b0;
      outExtraSym <= 1'b0;
    end else begin
      if (inValid) afterSop <= inSop && !inEop;
      outValid    <= keep;
      outSop      <= keep && inSop;
      outEop      <= keep && inEop;
      if (inValid) outData <= word;
      outSymErr   <= keep && inSop && strobe.symErr;
      outDispErr  <= keep && inSop && strobe.dispErr;
      outExtraSym <= keep && inEop && strobe.extraSym;
    end
  end

endmodule

// File: rtl/ctrl_frame_injector.sv
module ctrl_frame_injector
  import inj_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int KIND_LSB   = 12,
  parameter int KIND_W     = 4,
  parameter int FC_KIND    = 1,
  parameter int PA_KIND    = 2,
  parameter int CREQ_BIT   = 11,
  parameter int FCRSV_LSB  = 9,
  parameter int FCRSV_W    = 2,
  parameter int TC_BIT     = 8,
  parameter int CODE_LSB   = 5,
  parameter int SEQ_LSB    = 0,
  parameter int SEQ_W      = 5,
  parameter int CREDIT_LSB = 0,
  parameter int CREDIT_W   = 8,
  parameter int FUNC_LSB   = 8,
  parameter int FUNC_W     = 4,
  parameter int CAP_FUNC   = 3,
  parameter int PARSV_LSB  = 6,
  parameter int PARSV_W    = 2,
  parameter int CRC_LSB    = 0,
  parameter int CRC_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [3:0]        cmdOp,
  input  logic [7:0]        cmdArg,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic [DATA_W-1:0] outData,
  output logic              outSymErr,
  output logic              outDispErr,
  output logic              outExtraSym,
  output logic              injDone
);

  injStrobe_t strobe;
  logic       frameOn;

  inj_ctrl #(
    .KIND_W(KIND_W), .FC_KIND(FC_KIND), .PA_KIND(PA_KIND),
    .FUNC_W(FUNC_W), .CAP_FUNC(CAP_FUNC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrite(cmdWrite), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .hdrKind(inData[KIND_LSB +: KIND_W]),
    .hdrTc(inData[TC_BIT]),
    .hdrFunc(inData[FUNC_LSB +: FUNC_W]),
    .strobe(strobe), .frameOn(frameOn), .injDone(injDone)
  );

  inj_datapath #(
    .DATA_W(DATA_W), .CREQ_BIT(CREQ_BIT), .FCRSV_LSB(FCRSV_LSB), .FCRSV_W(FCRSV_W),
    .TC_BIT(TC_BIT), .CODE_LSB(CODE_LSB), .SEQ_LSB(SEQ_LSB), .SEQ_W(SEQ_W),
    .CREDIT_LSB(CREDIT_LSB), .CREDIT_W(CREDIT_W), .FUNC_LSB(FUNC_LSB), .FUNC_W(FUNC_W),
    .PARSV_LSB(PARSV_LSB), .PARSV_W(PARSV_W), .CRC_LSB(CRC_LSB), .CRC_W(CRC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSop(inSop), .inEop(inEop), .inData(inData),
    .strobe(strobe),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outData(outData),
    .outSymErr(outSymErr), .outDispErr(outDispErr), .outExtraSym(outExtraSym)
  );

endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inEop,
  input logic [DATA_W-1:0] inData,
  input logic              frameOn,
  input logic              outValid,
  input logic              outSop,
  input logic              outEop,
  input logic [DATA_W-1:0] outData,
  input logic              outSymErr,
  input logic              outDispErr,
  input logic              outExtraSym,
  input logic              injDone
);

  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !frameOn) |-> (outValid && outData == $past(inData)));

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R3
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    injDone |-> $past(inValid && inEop));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    injDone |=> !injDone);

  // R8
  sym_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSymErr || outDispErr) |-> (outValid && outSop));

  // R8
  extra_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    outExtraSym |-> (outValid && outEop));

endmodule

bind ctrl_frame_injector inj_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEop(inEop), .inData(inData),
  .frameOn(frameOn), .outValid(outValid), .outSop(outSop), .outEop(outEop),
  .outData(outData), .outSymErr(outSymErr), .outDispErr(outDispErr),
  .outExtraSym(outExtraSym), .injDone(injDone)
);

// File: tb/ctrl_frame_injector_bench.sv
`timescale 1ns/1ps
module ctrl_frame_injector_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [3:0]  cmdOp = 4'd0;
  logic [7:0]  cmdArg = 8'd0;
  logic        inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [15:0] inData = 16'd0;
  logic        outValid, outSop, outEop, outSymErr, outDispErr, outExtraSym, injDone;
  logic [15:0] outData;

  int total = 0;
  int fails = 0;

  logic [15:0] capD [8];
  logic [4:0]  capF [8];   // {sop, eop, sym, disp, extra}
  int capN = 0;
  int doneCnt = 0;

  always #5 clk = ~clk;

  ctrl_frame_injector u_ctrl_frame_injector (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .inValid(inValid), .inSop(inSop), .inEop(inEop), .inData(inData),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outData(outData),
    .outSymErr(outSymErr), .outDispErr(outDispErr), .outExtraSym(outExtraSym),
    .injDone(injDone)
  );

  always @(negedge clk) begin
    if (outValid && capN < 8) begin
      capD[capN] = outData;
      capF[capN] = {outSop, outEop, outSymErr, outDispErr, outExtraSym};
      capN++;
    end
    if (injDone) doneCnt++;
  end

  function automatic logic [15:0] fcH(logic creq, logic [1:0] rsv, logic tc,
                                      logic [2:0] code, logic [4:0] seq);
    return {4'h1, creq, rsv, tc, code, seq};
  endfunction

  function automatic logic [15:0] paH(logic [3:0] func, logic [1:0] rsv, logic [5:0] low);
    return {4'h2, func, rsv, low};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [3:0] op, logic [7:0] arg);
    cmdWrite = 1'b1; cmdOp = op; cmdArg = arg;
    tick();
    cmdWrite = 1'b0;
  endtask

  task automatic sendFrame(logic [15:0] w0, w1, w2, logic withCmd,
                           logic [3:0] op, logic [7:0] arg);
    capN = 0; doneCnt = 0;
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b0; inData = w0;
    if (withCmd) begin cmdWrite = 1'b1; cmdOp = op; cmdArg = arg; end
    tick();
    cmdWrite = 1'b0; inSop = 1'b0; inData = w1;
    tick();
    inEop = 1'b1; inData = w2;
    tick();
    inValid = 1'b0; inEop = 1'b0; inData = 16'h0;
    tick();
    tick();
  endtask

  task automatic expect3(string tag, logic [15:0] e0, e1, e2, int expDone);
    chk({tag, " word count"}, capN, 3);
    chk({tag, " header"}, capD[0], e0);
    chk({tag, " second word"}, capD[1], e1);
    chk({tag, " last word"}, capD[2], e2);
    chk({tag, " done pulses"}, doneCnt, expDone);
  endtask

  task automatic runFrame(string tag, logic [15:0] w0, w1, w2,
                          logic [15:0] e0, e1, e2, int expDone);
    sendFrame(w0, w1, w2, 1'b0, 4'd0, 8'd0);
    expect3(tag, e0, e1, e2, expDone);
  endtask

  task automatic t_reset();
    chk("R1 reset outValid", outValid, 0);
    chk("R3 reset injDone", injDone, 0);
  endtask

  task automatic t_pass();
    logic [15:0] h = fcH(1'b0, 2'b00, 1'b0, 3'd2, 5'd7);
    runFrame("R1 passthrough fc", h, 16'h3340, 16'hBEEF, h, 16'h3340, 16'hBEEF, 0);
    chk("R1 flags header", capF[0], 5'b10000);
    chk("R1 flags last", capF[2], 5'b01000);
    runFrame("R1 passthrough pa", paH(4'd5, 2'b01, 6'd9), 16'h0102, 16'h5A5A,
             paH(4'd5, 2'b01, 6'd9), 16'h0102, 16'h5A5A, 0);
  endtask

  task automatic t_fcBits();
    logic [15:0] h = fcH(1'b0, 2'b01, 1'b0, 3'd1, 5'd3);
    cmd(4'd1, 8'd0);
    runFrame("R4 fc crc invert", h, 16'h0011, 16'hBEEF, h, 16'h0011, 16'h4110, 1);
    runFrame("R2 one shot after crc", h, 16'h0011, 16'hBEEF, h, 16'h0011, 16'hBEEF, 0);
    cmd(4'd2, 8'd0);
    runFrame("R4 credit request bit", h, 16'h0011, 16'h1234,
             fcH(1'b1, 2'b01, 1'b0, 3'd1, 5'd3), 16'h0011, 16'h1234, 1);
    cmd(4'd3, 8'd0);
    runFrame("R4 fc reserved invert", h, 16'h0011, 16'h1234,
             fcH(1'b0, 2'b10, 1'b0, 3'd1, 5'd3), 16'h0011, 16'h1234, 1);
  endtask

  task automatic t_seq();
    cmd(4'd4, 8'd0);
    runFrame("R5 seq increment wrap", fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd31), 16'h0, 16'h7777,
             fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd0), 16'h0, 16'h7777, 1);
    cmd(4'd5, 8'd0);
    runFrame("R5 seq decrement wrap", fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd0), 16'h0, 16'h7777,
             fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd31), 16'h0, 16'h7777, 1);
    cmd(4'd4, 8'd0);
    runFrame("R5 seq increment", fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd5), 16'h0, 16'h7777,
             fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd6), 16'h0, 16'h7777, 1);
  endtask

  task automatic t_tc();
    logic [15:0] h1 = fcH(1'b0, 2'b00, 1'b1, 3'd0, 5'd2);
    logic [15:0] h0 = fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd2);
    cmd(4'd6, 8'd0);
    runFrame("R6 tc1 frame untouched", h1, 16'h0005, 16'hCAFE, h1, 16'h0005, 16'hCAFE, 0);
    runFrame("R6 tc0 frame swapped", h0, 16'h0005, 16'hCAFE, h1, 16'h0005, 16'hCAFE, 1);
  endtask

  task automatic t_replace();
    logic [15:0] h = fcH(1'b0, 2'b00, 1'b0, 3'd2, 5'd9);
    cmd(4'd7, 8'hA5);
    runFrame("R7 credit replace", h, 16'h1234, 16'h0F0F, h, 16'h12A5, 16'h0F0F, 1);
    cmd(4'd8, 8'hFD);
    runFrame("R7 code replace", h, 16'h1234, 16'h0F0F,
             fcH(1'b0, 2'b00, 1'b0, 3'd5, 5'd9), 16'h1234, 16'h0F0F, 1);
  endtask

  task automatic t_symbol();
    logic [15:0] h = fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd1);
    cmd(4'd9, 8'd0);
    runFrame("R8 symbol error data", h, 16'h0001, 16'h2222, h, 16'h0001, 16'h2222, 1);
    chk("R8 symbol flag header", capF[0], 5'b10100);
    chk("R8 symbol flag second", capF[1], 5'b00000);
    chk("R8 symbol flag last", capF[2], 5'b01000);
    cmd(4'd10, 8'd0);
    runFrame("R8 disparity data", h, 16'h0001, 16'h2222, h, 16'h0001, 16'h2222, 1);
    chk("R8 disparity flag header", capF[0], 5'b10010);
    cmd(4'd11, 8'd0);
    runFrame("R8 extra symbol data", h, 16'h0001, 16'h2222, h, 16'h0001, 16'h2222, 1);
    chk("R8 extra flag header", capF[0], 5'b10000);
    chk("R8 extra flag last", capF[2], 5'b01001);
  endtask

  task automatic t_pa();
    logic [15:0] fh = fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd4);
    logic [15:0] ph = paH(4'd6, 2'b10, 6'd3);
    cmd(4'd12, 8'd0);
    runFrame("R2 pa op ignores fc frame", fh, 16'h0044, 16'hAAAA, fh, 16'h0044, 16'hAAAA, 0);
    runFrame("R9 pa crc invert", ph, 16'h0044, 16'hAAAA, ph, 16'h0044, 16'h5555, 1);
    cmd(4'd1, 8'd0);
    runFrame("R2 fc op ignores pa frame", ph, 16'h0044, 16'hAAAA, ph, 16'h0044, 16'hAAAA, 0);
    runFrame("R2 fc op hits later fc frame", fh, 16'h0044, 16'hAAAA, fh, 16'h0044, 16'h5555, 1);
    cmd(4'd13, 8'd0);
    runFrame("R9 pa reserved invert", ph, 16'h0044, 16'hAAAA, paH(4'd6, 2'b01, 6'd3),
             16'h0044, 16'hAAAA, 1);
    cmd(4'd14, 8'd0);
    runFrame("R9 function id wrap", paH(4'd15, 2'b00, 6'd1), 16'h0044, 16'hAAAA,
             paH(4'd0, 2'b00, 6'd1), 16'h0044, 16'hAAAA, 1);
  endtask

  task automatic t_skip();
    cmd(4'd15, 8'd0);
    runFrame("R10 non capability passes", paH(4'd2, 2'b00, 6'd0), 16'h0009, 16'h1111,
             paH(4'd2, 2'b00, 6'd0), 16'h0009, 16'h1111, 0);
    sendFrame(paH(4'd3, 2'b00, 6'd0), 16'h0009, 16'h1111, 1'b0, 4'd0, 8'd0);
    chk("R10 capability frame dropped", capN, 0);
    chk("R3 done on dropped frame", doneCnt, 1);
    runFrame("R10 next capability passes", paH(4'd3, 2'b00, 6'd0), 16'h0009, 16'h1111,
             paH(4'd3, 2'b00, 6'd0), 16'h0009, 16'h1111, 0);
  endtask

  task automatic t_sameCycle();
    logic [15:0] h = fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd8);
    sendFrame(h, 16'h0003, 16'h00FF, 1'b1, 4'd1, 8'd0);
    expect3("R11 write with header not applied", h, 16'h0003, 16'h00FF, 0);
    runFrame("R11 write applies to next frame", h, 16'h0003, 16'h00FF, h, 16'h0003, 16'hFF00, 1);
  endtask

  task automatic t_disarm();
    logic [15:0] h = fcH(1'b0, 2'b00, 1'b0, 3'd0, 5'd8);
    cmd(4'd1, 8'd0);
    cmd(4'd0, 8'd0);
    runFrame("R2 op zero disarms", h, 16'h0003, 16'h00FF, h, 16'h0003, 16'h00FF, 0);
    cmd(4'd1, 8'd0);
    cmd(4'd2, 8'd0);
    runFrame("R2 later write replaces", h, 16'h0003, 16'h00FF,
             fcH(1'b1, 2'b00, 1'b0, 3'd0, 5'd8), 16'h0003, 16'h00FF, 1);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rstN = 1'b1;
    tick();
    t_pass();
    t_fcBits();
    t_seq();
    t_tc();
    t_replace();
    t_symbol();
    t_pa();
    t_skip();
    t_sameCycle();
    t_disarm();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule